// File: doc/BRIEF.md
# Multi-Way Address-Space TLB Lookup

This block is the translation lookup stage for one side (instruction or data, chosen by a parameter) of a 32-bit processor. It holds several ways of translation entries. Each entry carries a virtual page tag, a physical page base, an 8-bit address-space identifier (ASID) and a 4-bit attribute. A request presents a virtual address, an access kind (load, store or fetch) and the current privilege ring. All ways are searched in parallel. The ASID of each candidate entry is mapped to a ring through a packed ring register. One cycle later the block reports either a translation or a cause code: miss, multi-hit, privilege violation or prohibited access.

Ways below the two high ways use small pages and can be written through an entry write port. When the parameter for fixed high ways is set, way 5 holds two 128 MiB pages and way 6 holds two 256 MiB pages. Both are loaded at reset and cannot be written. The ring register is written as a whole word. Page-table refill is left to the surrounding logic.

Top module: `tlb_lookup`

## Requirements
- R1: The ring register resets to 0x04030201 (byte k, bits 8k+7:8k, is the ASID of ring k) and is replaced whole by `ring_wdata` when `ring_we` is high. An entry's ring is the lowest k whose byte equals the entry's ASID.
- R2: An entry hits only when its stored tag equals the request address with the way's page offset cleared, its ASID is nonzero, and that ASID appears in some byte of the ring register.
- R3: When no way hits, the cause is the miss code: 16 on the instruction side, 24 on the data side.
- R4: When two or more ways hit, the cause is the multi-hit code (17 instruction, 25 data), whatever the ring and attribute of the hitting entries.
- R5: A single hit whose ring number is lower than `req_ring` yields the privilege code (18 instruction, 26 data). This check comes before the attribute check.
- R6: Attribute decode, with `rsp_rwx` bit 2 = read, bit 1 = write, bit 0 = execute. A value below 12 grants read, bit 0 adds execute, bit 1 adds write, and the cache mode is attribute bits 3:2 (0 bypass, 1 write-back, 2 write-through). Value 13 grants read and write with cache mode 3 (isolate). Values 12, 14 and 15 grant nothing, with cache mode 0.
- R7: The instruction side clears the read and write grants; the data side clears the execute grant. Access kind encoding: 0 load (needs read), 1 store (needs write), 2 fetch (needs execute), 3 never granted. A missing grant gives cause 20 on the instruction side. On the data side it gives 29 for a store and 28 for any other kind.
- R8: On success, `rsp_paddr` is the entry's physical base ORed with the request address bits below the page size. `rsp_page_size` is 2^shift: 4 KiB for writable ways, indexed by address bits 13:12; 128 MiB for fixed way 5, indexed by bit 27; 256 MiB for fixed way 6, indexed by bit 28. `rsp_ring` is the entry's ring.
- R9: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. A fault sets `rsp_fault` and forces paddr, page size, rwx, cache and ring to zero. A success gives `rsp_fault` 0 and cause 0.
- R10: After reset, every writable entry has ASID 0, so it cannot hit. The fixed ways hold ASID 1 entries: 0xD0000000→0x00000000 attribute 7, 0xD8000000→0x00000000 attribute 3, 0xE0000000→0xF0000000 attribute 7, 0xF0000000→0xF0000000 attribute 3.
- R11: An entry write to a writable way replaces the slot selected by `wr_way` and `wr_idx`. The tag and physical base are stored with their page offset cleared. A write to a fixed way has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address |
| req_type | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_ring | input | 2 | Current privilege ring |
| wr_en | input | 1 | Entry write strobe |
| wr_way | input | 3 | Way to write |
| wr_idx | input | 2 | Slot within the way |
| wr_vaddr | input | 32 | Virtual page tag to store |
| wr_paddr | input | 32 | Physical page base to store |
| wr_asid | input | 8 | ASID to store |
| wr_attr | input | 4 | Attribute to store |
| ring_we | input | 1 | Ring register write strobe |
| ring_wdata | input | 32 | New ring register value |
| rsp_valid | output | 1 | Result valid pulse |
| rsp_fault | output | 1 | Result is a fault |
| rsp_cause | output | 6 | Fault cause code, 0 on success |
| rsp_paddr | output | 32 | Physical address |
| rsp_page_size | output | 32 | Page size in bytes |
| rsp_rwx | output | 3 | Side-masked grants: read, write, execute |
| rsp_cache | output | 2 | Cache mode |
| rsp_ring | output | 2 | Ring of the hit entry |

## Verification
The hardest result to reach from the ports is the multi-hit fault. It needs the same page planted in two different ways, with both ASIDs present in the ring register. The stimulus writes one address into two ways and looks it up at every ring, including rings that would otherwise give a privilege fault. It then changes one copy's ASID to a value missing from the ring register, which turns the result back into a single hit. The first-match ring rule is reached by loading the ring register with a repeated byte. Attribute decoding is swept over all sixteen codes, every access kind and both sides. Each response is compared against a model of the entries that the bench itself planted.

// File: rtl/tlb_lookup_pkg.sv
package tlb_lookup_pkg;

    localparam logic [1:0] ACC_LOAD  = 2'd0;
    localparam logic [1:0] ACC_STORE = 2'd1;
    localparam logic [1:0] ACC_FETCH = 2'd2;

    localparam logic [5:0] CAUSE_NONE      = 6'd0;
    localparam logic [5:0] I_MISS          = 6'd16;
    localparam logic [5:0] I_MULTI         = 6'd17;
    localparam logic [5:0] I_PRIV          = 6'd18;
    localparam logic [5:0] I_PROHIB        = 6'd20;
    localparam logic [5:0] D_MISS          = 6'd24;
    localparam logic [5:0] D_MULTI         = 6'd25;
    localparam logic [5:0] D_PRIV          = 6'd26;
    localparam logic [5:0] D_LOAD_PROHIB   = 6'd28;
    localparam logic [5:0] D_STORE_PROHIB  = 6'd29;

    localparam logic [31:0] RING_RESET = 32'h0403_0201;

    typedef struct packed {
        logic [31:0] tag;
        logic [31:0] ppage;
        logic [7:0]  asid;
        logic [3:0]  attr;
    } tlb_entry_t;

    typedef struct packed {
        logic        valid;
        logic        fault;
        logic [5:0]  cause;
        logic [31:0] paddr;
        logic [31:0] psize;
        logic [2:0]  rwx;
        logic [1:0]  cache;
        logic [1:0]  ring;
    } tlb_rsp_t;

    // {found, ring}: the lowest byte equal to the ASID wins; ASID 0 never maps
    function automatic logic [2:0] ring_lookup(input logic [31:0] rings,
                                               input logic [7:0] asid);
        logic [2:0] r;
        r = 3'b000;
        if (asid != 8'd0) begin
            for (int k = 3; k >= 0; k--) begin
                if (rings[8*k +: 8] == asid) r = {1'b1, 2'(k)};
            end
        end
        return r;
    endfunction

    // 0: writable way, 1: fixed 128 MiB way, 2: fixed 256 MiB way
    function automatic int way_kind(input int w, input int fixed_high);
        if (fixed_high != 0 && w == 5) return 1;
        if (fixed_high != 0 && w == 6) return 2;
        return 0;
    endfunction

    function automatic int way_shift(input int kind, input int base);
        if (kind == 1) return 27;
        if (kind == 2) return 28;
        return base;
    endfunction

    function automatic tlb_entry_t boot_entry(input int kind, input int idx);
        tlb_entry_t e;
        e = '0;
        if (kind == 1) begin
            e.tag   = (idx == 0) ? 32'hD000_0000 : 32'hD800_0000;
            e.ppage = 32'h0000_0000;
            e.asid  = 8'd1;
            e.attr  = (idx == 0) ? 4'd7 : 4'd3;
        end else if (kind == 2) begin
            e.tag   = (idx == 0) ? 32'hE000_0000 : 32'hF000_0000;
            e.ppage = 32'hF000_0000;
            e.asid  = 8'd1;
            e.attr  = (idx == 0) ? 4'd7 : 4'd3;
        end
        return e;
    endfunction

endpackage

// File: rtl/tlb_ring_reg.sv
module tlb_ring_reg
    import tlb_lookup_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [31:0] wdata,
    output logic [31:0] rings
);
    logic [31:0] ring_d, ring_q;

    always_comb begin
        ring_d = ring_q;
        if (we) ring_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ring_q <= RING_RESET;
        else        ring_q <= ring_d;
    end

    assign rings = ring_q;
endmodule

// File: rtl/tlb_way.sv
module tlb_way
    import tlb_lookup_pkg::*;
#(
    parameter int KIND  = 0,
    parameter int SHIFT = 12,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_vaddr,
    input  logic [31:0]      wr_paddr,
    input  logic [7:0]       wr_asid,
    input  logic [3:0]       wr_attr,
    input  logic [31:0]      lk_vaddr,
    output logic             lk_match,
    output tlb_entry_t       lk_entry
);
    localparam int          ENTRIES   = 1 << IDX_W;
    localparam logic [31:0] PAGE_MASK = ~((32'd1 << SHIFT) - 32'd1);
    localparam bit          WRITABLE  = (KIND == 0);

    tlb_entry_t mem_d [ENTRIES];
    tlb_entry_t mem_q [ENTRIES];
    logic [IDX_W-1:0] lk_idx;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) mem_d[i] = mem_q[i];
        if (wr_en && WRITABLE) begin
            mem_d[wr_idx].tag   = wr_vaddr & PAGE_MASK;
            mem_d[wr_idx].ppage = wr_paddr & PAGE_MASK;
            mem_d[wr_idx].asid  = wr_asid;
            mem_d[wr_idx].attr  = wr_attr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) mem_q[i] <= boot_entry(KIND, i);
        end else begin
            for (int i = 0; i < ENTRIES; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign lk_idx   = lk_vaddr[SHIFT +: IDX_W];
    assign lk_entry = mem_q[lk_idx];
    assign lk_match = (lk_entry.asid != 8'd0) &&
                      (lk_entry.tag == (lk_vaddr & PAGE_MASK));
endmodule

// File: rtl/tlb_attr_decode.sv
module tlb_attr_decode #(
    parameter bit IS_DATA = 1'b1
) (
    input  logic [3:0] attr,
    output logic [2:0] rwx,
    output logic [1:0] cache
);
    logic [2:0] raw;

    always_comb begin
        raw   = 3'b000;
        cache = 2'd0;
        if (attr < 4'd12) begin
            raw   = {1'b1, attr[1], attr[0]};
            cache = attr[3:2];
        end else if (attr == 4'd13) begin
            raw   = 3'b110;
            cache = 2'd3;
        end
        rwx = IS_DATA ? (raw & 3'b110) : (raw & 3'b001);
    end
endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
    import tlb_lookup_pkg::*;
#(
    parameter int NWAYS      = 7,
    parameter int VAR_IDX_W  = 2,
    parameter int PAGE_SHIFT = 12,
    parameter bit FIXED_HIGH = 1'b1,
    parameter bit IS_DATA    = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [31:0]                req_vaddr,
    input  logic [1:0]                 req_type,
    input  logic [1:0]                 req_ring,
    input  logic                       wr_en,
    input  logic [$clog2(NWAYS)-1:0]   wr_way,
    input  logic [VAR_IDX_W-1:0]       wr_idx,
    input  logic [31:0]                wr_vaddr,
    input  logic [31:0]                wr_paddr,
    input  logic [7:0]                 wr_asid,
    input  logic [3:0]                 wr_attr,
    input  logic                       ring_we,
    input  logic [31:0]                ring_wdata,
    output logic                       rsp_valid,
    output logic                       rsp_fault,
    output logic [5:0]                 rsp_cause,
    output logic [31:0]                rsp_paddr,
    output logic [31:0]                rsp_page_size,
    output logic [2:0]                 rsp_rwx,
    output logic [1:0]                 rsp_cache,
    output logic [1:0]                 rsp_ring
);
    localparam int WAY_W = $clog2(NWAYS);
    localparam logic [5:0] C_MISS  = IS_DATA ? D_MISS  : I_MISS;
    localparam logic [5:0] C_MULTI = IS_DATA ? D_MULTI : I_MULTI;
    localparam logic [5:0] C_PRIV  = IS_DATA ? D_PRIV  : I_PRIV;

    logic [31:0] rings;
    logic [NWAYS-1:0] way_match, way_found, way_hit;
    tlb_entry_t  way_ent  [NWAYS];
    logic [31:0] way_mask [NWAYS];
    logic [1:0]  way_ring [NWAYS];

    tlb_ring_reg u_rings (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ring_we),
        .wdata (ring_wdata),
        .rings (rings)
    );

    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        localparam int K  = way_kind(w, int'(FIXED_HIGH));
        localparam int S  = way_shift(K, PAGE_SHIFT);
        localparam int IW = (K == 0) ? VAR_IDX_W : 1;
        logic [2:0] map;

        tlb_way #(.KIND(K), .SHIFT(S), .IDX_W(IW)) u_way (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en && (wr_way == WAY_W'(w))),
            .wr_idx   (wr_idx[IW-1:0]),
            .wr_vaddr (wr_vaddr),
            .wr_paddr (wr_paddr),
            .wr_asid  (wr_asid),
            .wr_attr  (wr_attr),
            .lk_vaddr (req_vaddr),
            .lk_match (way_match[w]),
            .lk_entry (way_ent[w])
        );

        assign map          = ring_lookup(rings, way_ent[w].asid);
        assign way_found[w] = map[2];
        assign way_ring[w]  = map[1:0];
        assign way_mask[w]  = ~((32'd1 << S) - 32'd1);
    end

    assign way_hit = way_match & way_found;

    tlb_entry_t  sel_ent;
    logic [31:0] sel_mask;
    logic [1:0]  sel_ring;
    logic        taken;
    logic [2:0]  dec_rwx;
    logic [1:0]  dec_cache;
    logic        granted;
    logic [5:0]  prohib_cause;
    tlb_rsp_t    rsp_d, rsp_q;

    always_comb begin
        taken    = 1'b0;
        sel_ent  = '0;
        sel_mask = '0;
        sel_ring = '0;
        for (int w = 0; w < NWAYS; w++) begin
            if (way_hit[w] && !taken) begin
                taken    = 1'b1;
                sel_ent  = way_ent[w];
                sel_mask = way_mask[w];
                sel_ring = way_ring[w];
            end
        end
    end

    tlb_attr_decode #(.IS_DATA(IS_DATA)) u_dec (
        .attr  (sel_ent.attr),
        .rwx   (dec_rwx),
        .cache (dec_cache)
    );

    always_comb begin
        case (req_type)
            ACC_LOAD:  granted = dec_rwx[2];
            ACC_STORE: granted = dec_rwx[1];
            ACC_FETCH: granted = dec_rwx[0];
            default:   granted = 1'b0;
        endcase
        if (!IS_DATA)                    prohib_cause = I_PROHIB;
        else if (req_type == ACC_STORE)  prohib_cause = D_STORE_PROHIB;
        else                             prohib_cause = D_LOAD_PROHIB;

        rsp_d       = '0;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            if (way_hit == '0) begin
                rsp_d.fault = 1'b1;
                rsp_d.cause = C_MISS;
            end else if ($countones(way_hit) > 1) begin
                rsp_d.fault = 1'b1;
                rsp_d.cause = C_MULTI;
            end else if (sel_ring < req_ring) begin
                rsp_d.fault = 1'b1;
                rsp_d.cause = C_PRIV;
            end else if (!granted) begin
                rsp_d.fault = 1'b1;
                rsp_d.cause = prohib_cause;
            end else begin
                rsp_d.cause = CAUSE_NONE;
                rsp_d.paddr = sel_ent.ppage | (req_vaddr & ~sel_mask);
                rsp_d.psize = ~sel_mask + 32'd1;
                rsp_d.rwx   = dec_rwx;
                rsp_d.cache = dec_cache;
                rsp_d.ring  = sel_ring;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid     = rsp_q.valid;
    assign rsp_fault     = rsp_q.fault;
    assign rsp_cause     = rsp_q.cause;
    assign rsp_paddr     = rsp_q.paddr;
    assign rsp_page_size = rsp_q.psize;
    assign rsp_rwx       = rsp_q.rwx;
    assign rsp_cache     = rsp_q.cache;
    assign rsp_ring      = rsp_q.ring;
endmodule

// File: rtl/tlb_lookup_chk.sv
module tlb_lookup_chk #(
    parameter bit IS_DATA = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [31:0] req_vaddr,
    input logic [1:0]  req_type,
    input logic [1:0]  req_ring,
    input logic        rsp_valid,
    input logic        rsp_fault,
    input logic [5:0]  rsp_cause,
    input logic [31:0] rsp_paddr,
    input logic [31:0] rsp_page_size,
    input logic [2:0]  rsp_rwx,
    input logic [1:0]  rsp_cache,
    input logic [1:0]  rsp_ring
);
    a_r9_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (rsp_valid == $past(req_valid)));

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_fault && rsp_cause == 6'd0));

    a_r9_fault_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_paddr == 32'd0 && rsp_page_size == 32'd0 &&
                       rsp_rwx == 3'd0 && rsp_ring == 2'd0 && rsp_cause != 6'd0));

    a_r8_page_pow2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> ($countones(rsp_page_size) == 1));

    a_r8_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |->
        (((rsp_paddr ^ $past(req_vaddr)) & (rsp_page_size - 32'd1)) == 32'd0));

    a_r5_ring_allowed: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_ring >= $past(req_ring)));

    a_r7_side_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |->
        (IS_DATA ? (rsp_rwx[0] == 1'b0) : (rsp_rwx[2:1] == 2'b00)));

    a_r7_store_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault && $past(req_type) == 2'd1) |-> rsp_rwx[1]);

    a_r6_isolate_no_exec: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault && rsp_cache == 2'd3) |-> !rsp_rwx[0]);
endmodule

bind tlb_lookup tlb_lookup_chk #(.IS_DATA(IS_DATA)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_vaddr     (req_vaddr),
    .req_type      (req_type),
    .req_ring      (req_ring),
    .rsp_valid     (rsp_valid),
    .rsp_fault     (rsp_fault),
    .rsp_cause     (rsp_cause),
    .rsp_paddr     (rsp_paddr),
    .rsp_page_size (rsp_page_size),
    .rsp_rwx       (rsp_rwx),
    .rsp_cache     (rsp_cache),
    .rsp_ring      (rsp_ring)
);

// File: tb/tlb_lookup_tb.sv
module tlb_lookup_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        req_valid = 0;
    logic [31:0] req_vaddr = 0;
    logic [1:0]  req_type = 0, req_ring = 0;
    logic        wr_en = 0;
    logic [2:0]  wr_way = 0;
    logic [1:0]  wr_idx = 0;
    logic [31:0] wr_vaddr = 0, wr_paddr = 0;
    logic [7:0]  wr_asid = 0;
    logic [3:0]  wr_attr = 0;
    logic        ring_we = 0;
    logic [31:0] ring_wdata = 0;

    logic d_valid, d_fault, i_valid, i_fault;
    logic [5:0] d_cause, i_cause;
    logic [31:0] d_paddr, d_psize, i_paddr, i_psize;
    logic [2:0] d_rwx, i_rwx;
    logic [1:0] d_cache, d_ring, i_cache, i_ring;

    tlb_lookup #(.IS_DATA(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_type(req_type), .req_ring(req_ring), .wr_en(wr_en), .wr_way(wr_way),
        .wr_idx(wr_idx), .wr_vaddr(wr_vaddr), .wr_paddr(wr_paddr), .wr_asid(wr_asid),
        .wr_attr(wr_attr), .ring_we(ring_we), .ring_wdata(ring_wdata),
        .rsp_valid(d_valid), .rsp_fault(d_fault), .rsp_cause(d_cause),
        .rsp_paddr(d_paddr), .rsp_page_size(d_psize), .rsp_rwx(d_rwx),
        .rsp_cache(d_cache), .rsp_ring(d_ring));

    tlb_lookup #(.IS_DATA(1'b0)) u_dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_type(req_type), .req_ring(req_ring), .wr_en(wr_en), .wr_way(wr_way),
        .wr_idx(wr_idx), .wr_vaddr(wr_vaddr), .wr_paddr(wr_paddr), .wr_asid(wr_asid),
        .wr_attr(wr_attr), .ring_we(ring_we), .ring_wdata(ring_wdata),
        .rsp_valid(i_valid), .rsp_fault(i_fault), .rsp_cause(i_cause),
        .rsp_paddr(i_paddr), .rsp_page_size(i_psize), .rsp_rwx(i_rwx),
        .rsp_cache(i_cache), .rsp_ring(i_ring));

    int tests = 0;
    int fails = 0;

    // bench-side model of planted entries
    logic [31:0] m_tag  [7][4];
    logic [31:0] m_pa   [7][4];
    logic [7:0]  m_asid [7][4];
    logic [3:0]  m_attr [7][4];
    logic [31:0] m_ring;

    function automatic int shift_of(input int w);
        return (w == 5) ? 27 : (w == 6) ? 28 : 12;
    endfunction

    function automatic logic [31:0] low_mask(input int w);
        return (32'h1 << shift_of(w)) - 32'h1;
    endfunction

    function automatic logic [78:0] model(input logic [31:0] va, input logic [1:0] ty,
                                          input logic [1:0] rg, input bit isd);
        int nh, hw, hi, hr, idx, r;
        bit rd, wt, ex, ok;
        logic [1:0] cm;
        logic [5:0] cause;
        logic [3:0] a;
        nh = 0; hw = -1; hi = 0; hr = 0;
        for (int w = 0; w < 7; w++) begin
            idx = (w >= 5) ? int'((va >> shift_of(w)) & 32'h1) : int'((va >> 12) & 32'h3);
            if (m_asid[w][idx] != 0 && m_tag[w][idx] == (va & ~low_mask(w))) begin
                r = -1;
                for (int k = 0; k < 4; k++)
                    if (r < 0 && m_ring[8*k +: 8] == m_asid[w][idx]) r = k;
                if (r >= 0) begin
                    nh++;
                    if (hw < 0) begin hw = w; hi = idx; hr = r; end
                end
            end
        end
        if (nh == 0) return {1'b1, 1'b1, isd ? 6'd24 : 6'd16, 71'd0};
        if (nh > 1)  return {1'b1, 1'b1, isd ? 6'd25 : 6'd17, 71'd0};
        if (hr < int'(rg)) return {1'b1, 1'b1, isd ? 6'd26 : 6'd18, 71'd0};
        a  = m_attr[hw][hi];
        rd = (a < 12) || (a == 13);
        wt = ((a < 12) && a[1]) || (a == 13);
        ex = (a < 12) && a[0];
        cm = (a < 12) ? a[3:2] : (a == 13) ? 2'd3 : 2'd0;
        if (isd) ex = 0; else begin rd = 0; wt = 0; end
        ok = (ty == 0) ? rd : (ty == 1) ? wt : (ty == 2) ? ex : 1'b0;
        if (!ok) begin
            cause = !isd ? 6'd20 : (ty == 1) ? 6'd29 : 6'd28;
            return {1'b1, 1'b1, cause, 71'd0};
        end
        return {1'b1, 1'b0, 6'd0, m_pa[hw][hi] | (va & low_mask(hw)),
                low_mask(hw) + 32'h1, rd, wt, ex, cm, 2'(hr)};
    endfunction

    task automatic check(input logic [78:0] act, input logic [78:0] exp,
                         input string rq, input string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic lookup(input logic [31:0] va, input logic [1:0] ty,
                          input logic [1:0] rg, input string rq);
        @(negedge clk);
        req_valid = 1; req_vaddr = va; req_type = ty; req_ring = rg;
        @(negedge clk);
        req_valid = 0;
        check({d_valid, d_fault, d_cause, d_paddr, d_psize, d_rwx, d_cache, d_ring},
              model(va, ty, rg, 1'b1), rq, "data side");
        check({i_valid, i_fault, i_cause, i_paddr, i_psize, i_rwx, i_cache, i_ring},
              model(va, ty, rg, 1'b0), rq, "instr side");
    endtask

    task automatic write_entry(input int w, input int i, input logic [31:0] va,
                               input logic [31:0] pa, input logic [7:0] asid,
                               input logic [3:0] attr);
        @(negedge clk);
        wr_en = 1; wr_way = 3'(w); wr_idx = 2'(i);
        wr_vaddr = va; wr_paddr = pa; wr_asid = asid; wr_attr = attr;
        @(negedge clk);
        wr_en = 0;
        if (w < 5) begin
            m_tag[w][i] = va & ~low_mask(w);
            m_pa[w][i]  = pa & ~low_mask(w);
            m_asid[w][i] = asid;
            m_attr[w][i] = attr;
        end
    endtask

    task automatic write_rings(input logic [31:0] v);
        @(negedge clk);
        ring_we = 1; ring_wdata = v;
        @(negedge clk);
        ring_we = 0;
        m_ring = v;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int w = 0; w < 7; w++)
            for (int i = 0; i < 4; i++) begin
                m_tag[w][i] = 0; m_pa[w][i] = 0; m_asid[w][i] = 0; m_attr[w][i] = 0;
            end
        m_tag[5][0] = 32'hD000_0000; m_pa[5][0] = 0; m_asid[5][0] = 1; m_attr[5][0] = 7;
        m_tag[5][1] = 32'hD800_0000; m_pa[5][1] = 0; m_asid[5][1] = 1; m_attr[5][1] = 3;
        m_tag[6][0] = 32'hE000_0000; m_pa[6][0] = 32'hF000_0000; m_asid[6][0] = 1; m_attr[6][0] = 7;
        m_tag[6][1] = 32'hF000_0000; m_pa[6][1] = 32'hF000_0000; m_asid[6][1] = 1; m_attr[6][1] = 3;
        m_ring = 32'h0403_0201;

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R9: idle after reset
        check({77'd0, d_valid, i_valid}, 79'd0, "R9", "reset valid");
        check({73'd0, d_cause, 6'd0} | {78'd0, d_fault}, 79'd0, "R9", "reset fault");

        // R10: fixed preloads and empty writable ways
        for (int t = 0; t < 3; t++) begin
            lookup(32'hD123_4567, 2'(t), 2'd0, "R10");
            lookup(32'hDC00_0010, 2'(t), 2'd0, "R10");
            lookup(32'hE765_4320, 2'(t), 2'd0, "R10");
            lookup(32'hFABC_DEF0, 2'(t), 2'd0, "R10");
        end
        lookup(32'h0000_1000, 2'd0, 2'd0, "R3");
        lookup(32'h1234_5000, 2'd2, 2'd0, "R3");
        // R9: pulse lasts one cycle
        @(negedge clk);
        check({78'd0, d_valid}, 79'd0, "R9", "valid pulse width");

        // R6 / R7: attribute sweep, all kinds, both sides
        for (int a = 0; a < 16; a++) begin
            write_entry(1, 1, 32'h1234_5000, 32'h8765_4000, 8'd1, 4'(a));
            for (int t = 0; t < 4; t++) lookup(32'h1234_5ABC, 2'(t), 2'd0, "R6");
        end

        // R1 / R2 / R5: ASID to ring mapping and privilege
        begin
            logic [7:0] asids [6] = '{8'd1, 8'd2, 8'd3, 8'd4, 8'd0, 8'h55};
            for (int k = 0; k < 6; k++) begin
                write_entry(0, 2, 32'h0000_2000, 32'h0004_2000, asids[k], 4'd15 - 4'd8);
                for (int r = 0; r < 4; r++) lookup(32'h0000_2010, 2'd0, 2'(r), "R5");
            end
        end
        write_rings(32'h0101_0203);
        write_entry(0, 2, 32'h0000_2000, 32'h0004_2000, 8'd1, 4'd7);
        for (int r = 0; r < 4; r++) lookup(32'h0000_2020, 2'd1, 2'(r), "R1");
        lookup(32'hD000_0040, 2'd0, 2'd3, "R1");
        write_rings(32'h0403_0201);
        lookup(32'h0000_2020, 2'd1, 2'd1, "R1");

        // R4: multi-hit beats privilege and permission
        write_entry(2, 3, 32'h4000_3000, 32'h0010_3000, 8'd1, 4'd12);
        write_entry(3, 3, 32'h4000_3000, 32'h0020_3000, 8'd2, 4'd7);
        for (int r = 0; r < 4; r++) lookup(32'h4000_3008, 2'd1, 2'(r), "R4");
        write_entry(3, 3, 32'h4000_3000, 32'h0020_3000, 8'h99, 4'd7);
        lookup(32'h4000_3008, 2'd1, 2'd0, "R2");
        write_entry(2, 3, 32'h4000_3000, 32'h0010_3000, 8'd0, 4'd7);
        write_entry(3, 3, 32'h4000_3000, 32'h0020_3000, 8'd4, 4'd5);
        lookup(32'h4000_3008, 2'd0, 2'd3, "R2");
        lookup(32'h4000_3008, 2'd2, 2'd2, "R2");

        // R11: writes to fixed ways ignored, overwrite of a writable slot
        write_entry(5, 0, 32'hD000_0000, 32'h1234_0000, 8'd3, 4'd1);
        write_entry(6, 1, 32'hF000_0000, 32'h0000_0000, 8'd0, 4'd0);
        lookup(32'hD000_0100, 2'd0, 2'd0, "R11");
        lookup(32'hF000_0100, 2'd2, 2'd0, "R11");
        write_entry(1, 1, 32'h1234_5FFF, 32'h5555_5FFF, 8'd2, 4'd6);
        lookup(32'h1234_5ABC, 2'd1, 2'd1, "R11");

        // R8: offsets and page boundaries
        write_entry(4, 0, 32'h7654_C123, 32'hABCD_E123, 8'd3, 4'd7);
        lookup(32'h7654_CFFF, 2'd0, 2'd0, "R8");
        lookup(32'h7654_C001, 2'd2, 2'd2, "R8");
        lookup(32'h7654_D000, 2'd0, 2'd0, "R8");
        lookup(32'h7655_C000, 2'd0, 2'd0, "R8");
        lookup(32'hDFFF_FFFF, 2'd0, 2'd0, "R8");
        lookup(32'hEFFF_FFFC, 2'd1, 2'd0, "R8");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule